// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block sits between instruction decode and issue. It takes one decoded vector-prefixed instruction and turns it into a run of element operations, one for each value of a step index. That index lives in an architectural vector-state register, alongside the vector length (VL) and the maximum vector length (MVL). Each element operation goes to issue as its own packet over a ready/valid handshake, in strict program order. Downstream hazard logic can therefore treat every element as a separate sequential instruction.

For each element, an operand flagged as vector gets its register number advanced by the step index. An operand flagged as scalar keeps its base number. A set-length port loads VL and MVL, with VL clamped to MVL. The step index behaves as a sub-program-counter. On trap entry the whole vector state is copied into a save register, in the same cycle the core saves PC and MSR. On trap return it is copied back. When the interrupted instruction is decoded again, the loop resumes at the element that had not completed.

Top module: `vloop_seq`

## Requirements
- R1: After reset the vector length, maximum length, step index and all three save fields read 0, `dec_ready` is 1, and `iss_valid` and `insn_done` are 0.
- R2: A set-length write (`setvl_we`), taken while no loop runs and no trap signal is high, loads MVL with `setvl_mvl`, loads VL with the smaller of `setvl_vl` and `setvl_mvl`, and clears the step index. While a loop runs, the write is ignored and VL, MVL and the step index keep their values.
- R3: `dec_ready` is 1 only when no loop is running and `trap_enter`, `trap_return` and `setvl_we` are all 0. A decode is taken only on a cycle where `dec_valid` and `dec_ready` are both 1.
- R4: With VL > 0, a taken decode starts a loop. `iss_valid` is 1 while the loop runs, except in a cycle where a trap signal is high. `iss_step` starts at the current step index and advances by one on each accepted packet, up to VL-1. `iss_last` is 1 when `iss_step + 1 >= VL`.
- R5: In each packet, operand i (field bits [i*REG_W +: REG_W]) with `dec_vec[i]`=1 carries (base + step) mod 2^REG_W. With `dec_vec[i]`=0 it carries the base unchanged. `iss_tag` equals the decoded tag.
- R6: While `iss_valid` is 1 and `iss_ready` is 0, the packet (`iss_regs`, `iss_tag`, `iss_step`) stays unchanged into the next cycle, unless a trap signal rises.
- R7: When the packet with `iss_last`=1 is accepted, the step index returns to 0, the loop ends, and `insn_done` is 1 for exactly the following cycle.
- R8: A decode taken while VL is 0 issues no packet. `insn_done` is 1 in the next cycle and the step index stays 0.
- R9: On `trap_enter`, the save fields take the current VL, MVL and step index at that clock edge, and any running loop is abandoned. The step index is left at the element that was not accepted, and `iss_valid` is 0 during the trap cycle.
- R10: On `trap_return` (without `trap_enter`), VL, MVL and the step index are reloaded from the save fields. A following decode of the same instruction resumes at the saved step.
- R11: Priority is `trap_enter`, then `trap_return`, then set-length, then loop stepping. With both trap signals high, only the save happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_ready | output | 1 | Sequencer can take a decode |
| dec_base | input | NOPS*REG_W | Base register number per operand |
| dec_vec | input | NOPS | Per operand: 1 = vector, 0 = scalar |
| dec_tag | input | TAG_W | Opaque operation tag |
| iss_valid | output | 1 | Element packet present |
| iss_ready | input | 1 | Issue accepts the packet |
| iss_regs | output | NOPS*REG_W | Per-element register numbers |
| iss_tag | output | TAG_W | Tag of the looping instruction |
| iss_step | output | SV_W | Element index of this packet |
| iss_last | output | 1 | Final element of the loop |
| insn_done | output | 1 | Instruction retired pulse |
| setvl_we | input | 1 | Set-length write |
| setvl_vl | input | SV_W | Requested vector length |
| setvl_mvl | input | SV_W | New maximum vector length |
| trap_enter | input | 1 | Exception entry, save state |
| trap_return | input | 1 | Exception return, restore state |
| sv_vl | output | SV_W | Current VL |
| sv_mvl | output | SV_W | Current MVL |
| sv_step | output | SV_W | Current step index |
| sav_vl | output | SV_W | Saved VL |
| sav_mvl | output | SV_W | Saved MVL |
| sav_step | output | SV_W | Saved step index |

## Verification
Random mixes of set-length writes, decodes with random base numbers and vector/scalar masks, random issue back-pressure and occasional traps are compared every cycle against a cycle model. This separates step counting errors from operand remap errors, because the two show up on different packet fields. Directed cases cover each remaining corner. A requested length above MVL shows the clamp. Zero length separates instant retirement from a spurious packet. A stalled packet shows hold stability. A base near the top of the register space shows wraparound. A trap taken mid-loop followed by a return and re-decode separates resuming at the saved element from restarting at element 0. Both trap signals high together shows the priority order.

// File: rtl/vls_pkg.sv
package vls_pkg;
  parameter int unsigned SV_W = 7;

  typedef logic [SV_W-1:0] svfield_t;

  typedef struct packed {
    svfield_t vl;
    svfield_t mvl;
    svfield_t step;
  } svstate_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_LOOP = 1'b1} seq_st_e;
endpackage

// File: rtl/vls_state.sv
module vls_state
  import vls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trap_enter,
  input  logic     trap_return,
  input  logic     setvl_en,
  input  svfield_t setvl_vl,
  input  svfield_t setvl_mvl,
  input  logic     step_inc,
  input  logic     step_zero,
  output svstate_t cur_o,
  output svstate_t save_o
);
  svstate_t cur_q, cur_d, save_q, save_d;
  logic     cur_en, save_en;
  svfield_t vl_clamped;

  assign vl_clamped = (setvl_vl > setvl_mvl) ? setvl_mvl : setvl_vl;

  always_comb begin
    cur_d   = cur_q;
    save_d  = save_q;
    cur_en  = 1'b0;
    save_en = 1'b0;
    if (trap_enter) begin
      save_d  = cur_q;
      save_en = 1'b1;
    end else if (trap_return) begin
      cur_d  = save_q;
      cur_en = 1'b1;
    end else if (setvl_en) begin
      cur_d.vl   = vl_clamped;
      cur_d.mvl  = setvl_mvl;
      cur_d.step = '0;
      cur_en     = 1'b1;
    end else if (step_zero) begin
      cur_d.step = '0;
      cur_en     = 1'b1;
    end else if (step_inc) begin
      cur_d.step = cur_q.step + svfield_t'(1);
      cur_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      save_q <= '0;
    end else begin
      if (cur_en)  cur_q  <= cur_d;
      if (save_en) save_q <= save_d;
    end
  end

  assign cur_o  = cur_q;
  assign save_o = save_q;
endmodule

// File: rtl/vls_remap.sv
module vls_remap
  import vls_pkg::*;
#(
  parameter int unsigned NOPS  = 3,
  parameter int unsigned REG_W = 7
) (
  input  logic [NOPS*REG_W-1:0] base_i,
  input  logic [NOPS-1:0]       vec_i,
  input  svfield_t              step_i,
  output logic [NOPS*REG_W-1:0] regs_o
);
  localparam int unsigned SUM_W = (REG_W > SV_W) ? REG_W : SV_W;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(base_i[g*REG_W +: REG_W]) + SUM_W'(step_i);
    assign regs_o[g*REG_W +: REG_W] = vec_i[g] ? sum[REG_W-1:0]
                                               : base_i[g*REG_W +: REG_W];
  end
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int unsigned NOPS  = 3,
  parameter int unsigned REG_W = 7,
  parameter int unsigned TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  input  logic [NOPS*REG_W-1:0] dec_base,
  input  logic [NOPS-1:0]       dec_vec,
  input  logic [TAG_W-1:0]      dec_tag,
  input  logic                  iss_ready,
  input  logic                  trap_enter,
  input  logic                  trap_return,
  input  logic                  setvl_we,
  input  svstate_t              cur,
  output logic                  dec_ready,
  output logic                  iss_valid,
  output logic                  iss_last,
  output logic                  setvl_en,
  output logic                  step_inc,
  output logic                  step_zero,
  output logic                  insn_done,
  output logic [NOPS*REG_W-1:0] lat_base,
  output logic [NOPS-1:0]       lat_vec,
  output logic [TAG_W-1:0]      lat_tag
);
  seq_st_e st_q, st_d;
  logic    done_q, done_d;
  logic    idle, trap_any, accept, vl_zero, fire;
  logic [SV_W:0] step_plus;

  logic [NOPS*REG_W-1:0] base_q;
  logic [NOPS-1:0]       vec_q;
  logic [TAG_W-1:0]      tag_q;

  assign idle      = (st_q == ST_IDLE);
  assign trap_any  = trap_enter | trap_return;
  assign dec_ready = idle & ~trap_any & ~setvl_we;
  assign setvl_en  = setvl_we & idle & ~trap_any;
  assign accept    = dec_valid & dec_ready;
  assign vl_zero   = (cur.vl == '0);
  assign step_plus = {1'b0, cur.step} + {{SV_W{1'b0}}, 1'b1};
  assign iss_last  = (step_plus >= {1'b0, cur.vl});
  assign iss_valid = ~idle & ~trap_any;
  assign fire      = iss_valid & iss_ready;
  assign step_inc  = fire & ~iss_last;
  assign step_zero = (fire & iss_last) | (accept & vl_zero);

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    if (trap_any) begin
      st_d = ST_IDLE;
    end else if (accept) begin
      if (vl_zero) done_d = 1'b1;
      else         st_d   = ST_LOOP;
    end else if (fire && iss_last) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= '0;
      tag_q  <= '0;
    end else if (accept) begin
      base_q <= dec_base;
      vec_q  <= dec_vec;
      tag_q  <= dec_tag;
    end
  end

  assign insn_done = done_q;
  assign lat_base  = base_q;
  assign lat_vec   = vec_q;
  assign lat_tag   = tag_q;
endmodule

// File: rtl/vloop_seq.sv
module vloop_seq
  import vls_pkg::*;
#(
  parameter int unsigned NOPS  = 3,
  parameter int unsigned REG_W = 7,
  parameter int unsigned TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  output logic                  dec_ready,
  input  logic [NOPS*REG_W-1:0] dec_base,
  input  logic [NOPS-1:0]       dec_vec,
  input  logic [TAG_W-1:0]      dec_tag,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [NOPS*REG_W-1:0] iss_regs,
  output logic [TAG_W-1:0]      iss_tag,
  output logic [SV_W-1:0]       iss_step,
  output logic                  iss_last,
  output logic                  insn_done,
  input  logic                  setvl_we,
  input  logic [SV_W-1:0]       setvl_vl,
  input  logic [SV_W-1:0]       setvl_mvl,
  input  logic                  trap_enter,
  input  logic                  trap_return,
  output logic [SV_W-1:0]       sv_vl,
  output logic [SV_W-1:0]       sv_mvl,
  output logic [SV_W-1:0]       sv_step,
  output logic [SV_W-1:0]       sav_vl,
  output logic [SV_W-1:0]       sav_mvl,
  output logic [SV_W-1:0]       sav_step
);
  svstate_t              cur, save;
  logic                  setvl_en, step_inc, step_zero;
  logic [NOPS*REG_W-1:0] lat_base;
  logic [NOPS-1:0]       lat_vec;

  vls_ctrl #(.NOPS(NOPS), .REG_W(REG_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_base(dec_base), .dec_vec(dec_vec), .dec_tag(dec_tag),
    .iss_ready(iss_ready), .trap_enter(trap_enter), .trap_return(trap_return),
    .setvl_we(setvl_we), .cur(cur),
    .dec_ready(dec_ready), .iss_valid(iss_valid), .iss_last(iss_last),
    .setvl_en(setvl_en), .step_inc(step_inc), .step_zero(step_zero),
    .insn_done(insn_done), .lat_base(lat_base), .lat_vec(lat_vec), .lat_tag(iss_tag)
  );

  vls_state u_state (
    .clk(clk), .rst_n(rst_n),
    .trap_enter(trap_enter), .trap_return(trap_return),
    .setvl_en(setvl_en), .setvl_vl(setvl_vl), .setvl_mvl(setvl_mvl),
    .step_inc(step_inc), .step_zero(step_zero),
    .cur_o(cur), .save_o(save)
  );

  vls_remap #(.NOPS(NOPS), .REG_W(REG_W)) u_remap (
    .base_i(lat_base), .vec_i(lat_vec), .step_i(cur.step), .regs_o(iss_regs)
  );

  assign iss_step = cur.step;
  assign sv_vl    = cur.vl;
  assign sv_mvl   = cur.mvl;
  assign sv_step  = cur.step;
  assign sav_vl   = save.vl;
  assign sav_mvl  = save.mvl;
  assign sav_step = save.step;
endmodule

// File: rtl/vloop_seq_chk.sv
module vloop_seq_chk
  import vls_pkg::*;
#(
  parameter int unsigned NOPS  = 3,
  parameter int unsigned REG_W = 7,
  parameter int unsigned TAG_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dec_valid,
  input logic                  dec_ready,
  input logic                  iss_valid,
  input logic                  iss_ready,
  input logic [NOPS*REG_W-1:0] iss_regs,
  input logic [TAG_W-1:0]      iss_tag,
  input logic [SV_W-1:0]       iss_step,
  input logic                  iss_last,
  input logic                  insn_done,
  input logic                  trap_enter,
  input logic                  trap_return,
  input logic [SV_W-1:0]       sv_vl,
  input logic [SV_W-1:0]       sv_mvl,
  input logic [SV_W-1:0]       sv_step,
  input logic [SV_W-1:0]       sav_vl,
  input logic [SV_W-1:0]       sav_mvl,
  input logic [SV_W-1:0]       sav_step
);
  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sv_vl <= sv_mvl);

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ready |-> !iss_valid);

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_step < sv_vl));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> trap_enter || trap_return ||
      (iss_valid && $stable(iss_regs) && $stable(iss_tag) && $stable(iss_step)));

  assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && iss_last |=> insn_done && (sv_step == '0));

  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_ready && (sv_vl == '0) |=> insn_done && !iss_valid);

  assert_save_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> {sav_vl, sav_mvl, sav_step} == $past({sv_vl, sv_mvl, sv_step}));

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_return && !trap_enter |=> {sv_vl, sv_mvl, sv_step} == $past({sav_vl, sav_mvl, sav_step}));
endmodule

bind vloop_seq vloop_seq_chk #(.NOPS(NOPS), .REG_W(REG_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_regs(iss_regs),
  .iss_tag(iss_tag), .iss_step(iss_step), .iss_last(iss_last),
  .insn_done(insn_done), .trap_enter(trap_enter), .trap_return(trap_return),
  .sv_vl(sv_vl), .sv_mvl(sv_mvl), .sv_step(sv_step),
  .sav_vl(sav_vl), .sav_mvl(sav_mvl), .sav_step(sav_step)
);

// File: tb/vloop_seq_test.sv
module vloop_seq_test;
  import vls_pkg::*;
  localparam int NOPS  = 3;
  localparam int REG_W = 7;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic dec_valid, dec_ready, iss_valid, iss_ready, iss_last, insn_done;
  logic setvl_we, trap_enter, trap_return;
  logic [NOPS*REG_W-1:0] dec_base, iss_regs;
  logic [NOPS-1:0] dec_vec;
  logic [TAG_W-1:0] dec_tag, iss_tag;
  logic [SV_W-1:0] iss_step, setvl_vl, setvl_mvl;
  logic [SV_W-1:0] sv_vl, sv_mvl, sv_step, sav_vl, sav_mvl, sav_step;

  vloop_seq #(.NOPS(NOPS), .REG_W(REG_W), .TAG_W(TAG_W)) uut (.*);

  int total = 0;
  int bad = 0;

  // shadow inputs applied at the next falling edge
  logic n_dv, n_rdy, n_swe, n_te, n_tr;
  logic [NOPS*REG_W-1:0] n_base;
  logic [NOPS-1:0] n_vec;
  logic [TAG_W-1:0] n_tag;
  logic [SV_W-1:0] n_svl, n_smvl;

  // reference model
  int m_vl, m_mvl, m_step, s_vl, s_mvl, s_step;
  bit m_run, m_done;
  logic [NOPS*REG_W-1:0] m_base;
  logic [NOPS-1:0] m_vec;
  logic [TAG_W-1:0] m_tag;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NOPS*REG_W-1:0] exp_regs();
    logic [NOPS*REG_W-1:0] r;
    for (int i = 0; i < NOPS; i++) begin
      int b;
      b = int'(m_base[i*REG_W +: REG_W]);
      r[i*REG_W +: REG_W] = m_vec[i] ? REG_W'((b + m_step) % (1 << REG_W)) : REG_W'(b);
    end
    return r;
  endfunction

  function automatic bit exp_last();
    return (m_step + 1) >= m_vl;
  endfunction

  task automatic clear_shadow();
    n_dv = 0; n_rdy = 0; n_swe = 0; n_te = 0; n_tr = 0;
    n_base = '0; n_vec = '0; n_tag = '0; n_svl = '0; n_smvl = '0;
  endtask

  task automatic cyc();
    bit evalid, edr, fire;
    @(negedge clk);
    dec_valid = n_dv; iss_ready = n_rdy; setvl_we = n_swe;
    trap_enter = n_te; trap_return = n_tr; dec_base = n_base;
    dec_vec = n_vec; dec_tag = n_tag; setvl_vl = n_svl; setvl_mvl = n_smvl;
    #1;
    edr    = !m_run && !n_te && !n_tr && !n_swe;
    evalid = m_run && !n_te && !n_tr;
    chk("R3 dec_ready", dec_ready, edr);
    chk("R4 iss_valid", iss_valid, evalid);
    chk("R7 insn_done", insn_done, m_done);
    chk("R2 sv_vl", sv_vl, m_vl);
    chk("R2 sv_mvl", sv_mvl, m_mvl);
    chk("R10 sv_step", sv_step, m_step);
    chk("R9 sav_vl", sav_vl, s_vl);
    chk("R9 sav_mvl", sav_mvl, s_mvl);
    chk("R9 sav_step", sav_step, s_step);
    if (evalid) begin
      chk("R5 iss_regs", iss_regs, exp_regs());
      chk("R5 iss_tag", iss_tag, m_tag);
      chk("R4 iss_step", iss_step, m_step);
      chk("R4 iss_last", iss_last, exp_last());
    end
    // model next state, R11 priority order
    fire = evalid && n_rdy;
    m_done = 0;
    if (n_te) begin
      s_vl = m_vl; s_mvl = m_mvl; s_step = m_step; m_run = 0;
    end else if (n_tr) begin
      m_vl = s_vl; m_mvl = s_mvl; m_step = s_step; m_run = 0;
    end else if (!m_run && n_swe) begin
      m_mvl = int'(n_smvl);
      m_vl = (n_svl > n_smvl) ? int'(n_smvl) : int'(n_svl);
      m_step = 0;
    end else if (!m_run && n_dv) begin
      if (m_vl == 0) begin m_done = 1; m_step = 0; end
      else begin m_run = 1; m_base = n_base; m_vec = n_vec; m_tag = n_tag; end
    end else if (fire) begin
      if (exp_last()) begin m_step = 0; m_run = 0; m_done = 1; end
      else m_step++;
    end
    clear_shadow();
  endtask

  task automatic do_setvl(int vl, int mvl);
    n_swe = 1; n_svl = SV_W'(vl); n_smvl = SV_W'(mvl); cyc();
  endtask

  task automatic do_dec(logic [NOPS*REG_W-1:0] b, logic [NOPS-1:0] v, logic [TAG_W-1:0] t);
    n_dv = 1; n_base = b; n_vec = v; n_tag = t; cyc();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [NOPS*REG_W-1:0] held;
    clear_shadow();
    dec_valid = 0; iss_ready = 0; setvl_we = 0; trap_enter = 0; trap_return = 0;
    dec_base = '0; dec_vec = '0; dec_tag = '0; setvl_vl = '0; setvl_mvl = '0;
    m_vl = 0; m_mvl = 0; m_step = 0; s_vl = 0; s_mvl = 0; s_step = 0;
    m_run = 0; m_done = 0; m_base = '0; m_vec = '0; m_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk("R1 dec_ready", dec_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 insn_done", insn_done, 0);
    chk("R1 state", {sv_vl, sv_mvl, sv_step, sav_vl, sav_mvl, sav_step}, 0);

    // R8 zero length retires at once
    do_dec({7'd1, 7'd2, 7'd3}, 3'b111, 8'h11);
    cyc();
    chk("R8 done", insn_done, 1);
    chk("R8 no issue", iss_valid, 0);
    chk("R8 step", sv_step, 0);

    // R2 clamp of VL to MVL
    do_setvl(20, 8);
    cyc();
    chk("R2 clamp", sv_vl, 8);

    // R6 hold under back-pressure, then complete
    do_setvl(4, 8);
    do_dec({7'd30, 7'd20, 7'd10}, 3'b101, 8'h5A);
    cyc(); held = iss_regs;
    cyc();
    chk("R6 hold valid", iss_valid, 1);
    chk("R6 hold regs", iss_regs, held);
    // R2 set-length ignored during loop
    do_setvl(2, 3);
    chk("R2 ignored", sv_vl, 4);
    repeat (4) begin n_rdy = 1; cyc(); end
    cyc();

    // R5 wraparound near the top register number
    do_dec({7'd0, 7'd127, 7'd126}, 3'b011, 8'h77);
    repeat (4) begin n_rdy = 1; cyc(); end
    cyc();

    // R9/R10 trap mid-loop then resume
    do_setvl(6, 10);
    do_dec({7'd40, 7'd50, 7'd60}, 3'b111, 8'h33);
    repeat (2) begin n_rdy = 1; cyc(); end
    n_te = 1; n_rdy = 1; cyc();
    cyc();
    chk("R9 saved step", sav_step, 2);
    chk("R9 aborted", iss_valid, 0);
    do_setvl(1, 1);
    n_tr = 1; cyc();
    cyc();
    chk("R10 restored vl", sv_vl, 6);
    do_dec({7'd40, 7'd50, 7'd60}, 3'b111, 8'h33);
    cyc();
    chk("R10 resume step", iss_step, 2);
    repeat (4) begin n_rdy = 1; cyc(); end
    cyc();

    // R11 both trap signals: only save happens
    do_setvl(3, 5);
    n_te = 1; n_tr = 1; cyc();
    cyc();
    chk("R11 save wins", {sav_vl, sav_mvl}, {7'd3, 7'd5});
    chk("R11 cur kept", sv_mvl, 5);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom % 100);
      if (!m_run) begin
        if (r < 15) begin n_swe = 1; n_svl = SV_W'($urandom % 16); n_smvl = SV_W'($urandom % 13); end
        else if (r < 55) begin
          n_dv = 1; n_base = NOPS*REG_W'($urandom); n_vec = NOPS'($urandom); n_tag = TAG_W'($urandom);
        end
        else if (r < 60) n_tr = 1;
        else if (r < 63) n_te = 1;
      end else begin
        n_rdy = ($urandom % 10) < 7;
        if (r < 3) n_te = 1;
        else if (r < 13) begin n_swe = 1; n_svl = SV_W'($urandom % 16); n_smvl = SV_W'($urandom % 13); end
        else if (r < 20) begin n_dv = 1; n_base = NOPS*REG_W'($urandom); end
      end
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule